// File: doc/BRIEF.md
# ADC DMA Instruction Sequencer

This block moves analog conversion results into external RAM under the control of a small program. Software writes up to 64 one-byte instructions into an internal buffer. It also sets a boundary index where the program starts, a 16-bit repeat limit and a 16-bit RAM base address. A start pulse then launches the program. Each instruction names the converters whose results it wants. The sequencer waits until every named converter has delivered a sample, then writes each sample to RAM as two consecutive bytes.

Every instruction runs for a programmed number of passes before the sequencer moves to the next buffer entry. An instruction with an empty selection marks the end of the program. It sends execution back to the boundary index, and its top bit decides whether the program starts again or the sequencer halts and reports completion.

Top module: `adc_dma_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are low and no RAM write takes place until a start pulse arrives.
- R2: A start pulse seen while idle loads the instruction pointer `ins_ptr` from the boundary register, so the cycle after the start edge shows the boundary value, and it also loads the write address from the base register.
- R3: An instruction transfers nothing until every converter it selects has pulsed its ready line while the sequencer waits (`adc_wait` high). Ready pulses that arrive while idle, or that come from converters the instruction does not select, are ignored and cause no write.
- R4: Each selected sample is written with its high byte first and its low byte second. When both converters are selected, converter 1's two bytes come before converter 0's, whatever order the ready pulses arrived in.
- R5: Instruction bit 5 selects converter 1. Bit 4 selects converter 0 single-ended and bit 6 selects converter 0 differential. `adc0_diff` is high while an instruction with bit 6 set is waiting or writing. An instruction whose bits 6:4 are all zero is an end-of-program instruction.
- R6: With a repeat limit L of at least 1, each instruction runs L passes at the same `ins_ptr`. The repeat counter then reloads from the limit and the pointer advances by one. A limit of 0 gives 65536 passes.
- R7: An end-of-program instruction with bit 7 set returns `ins_ptr` to the boundary index and keeps running with `busy` high. The write address carries on from where it stopped.
- R8: An end-of-program instruction with bit 7 clear stops the sequencer. `busy` drops, `ins_ptr` equals the boundary index, and `done` is high for exactly one cycle, in the same cycle that `busy` falls.
- R9: The RAM write address goes up by one after every byte and wraps from 0xFFFF to 0x0000.
- R10: The instruction pointer wraps from 0x3F to 0x00 when it advances past the last buffer entry.
- R11: Register writes use this map: `reg_addr` 0x00–0x3F writes instruction bits 7:4 into the buffer, 0x40 sets the boundary (bits 5:0), 0x41 and 0x42 set the low and high bytes of the limit, and 0x43 and 0x44 set the low and high bytes of the base address.
- R12: A start pulse while `busy` is high has no effect on `ins_ptr` or on the running program.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register / buffer address |
| reg_wdata | input | 8 | Register write data |
| start | input | 1 | Start pulse, honoured only while idle |
| adc0_rdy | input | 1 | Converter 0 sample valid pulse |
| adc0_data | input | 16 | Converter 0 sample |
| adc1_rdy | input | 1 | Converter 1 sample valid pulse |
| adc1_data | input | 16 | Converter 1 sample |
| adc_wait | output | 1 | Sequencer is waiting for samples |
| adc0_diff | output | 1 | Current instruction wants converter 0 in differential mode |
| mem_we | output | 1 | RAM byte write strobe |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM byte data |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse when the program halts |
| ins_ptr | output | 6 | Current instruction index |

## Verification
The assertions assume that the boundary register is not rewritten while `busy` is high. The pointer checks compare a jump against the boundary value, so a boundary that changes during a run would break them. The bench writes the boundary, limit and base only while the sequencer is idle. While a program runs, it changes only buffer entries that have not yet been fetched. It drives ready pulses only after it has seen `adc_wait`, apart from deliberate stray pulses sent to show they are ignored. It does not send the next pass's samples until `adc_wait` has dropped, so each pulse is tied to one known pass.

// File: rtl/adc_dma_seq.sv
module adc_dma_seq #(
  parameter int DEPTH = 64,
  parameter int CW    = 16,
  parameter int MAW   = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [PW:0]    reg_addr,
  input  logic [7:0]     reg_wdata,
  input  logic           start,
  input  logic           adc0_rdy,
  input  logic [15:0]    adc0_data,
  input  logic           adc1_rdy,
  input  logic [15:0]    adc1_data,
  output logic           adc_wait,
  output logic           adc0_diff,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [7:0]     mem_wdata,
  output logic           busy,
  output logic           done,
  output logic [PW-1:0]  ins_ptr
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_WR} st_t;

  st_t            st;
  logic [3:0]     ibuf [DEPTH];
  logic [PW-1:0]  bnd, ptr;
  logic [CW-1:0]  lim, rcnt;
  logic [MAW-1:0] base, addr;
  logic [2:0]     sel;
  logic           got0, got1, done_q;
  logic [15:0]    s0, s1;
  logic [1:0]     bidx;

  wire        cfg_we = reg_we && reg_addr[PW];
  wire [3:0]  fi     = ibuf[ptr];
  wire        fi_eop = (fi[2:0] == 3'b000);
  wire        need0  = sel[0] | sel[2];
  wire        need1  = sel[1];
  wire [1:0]  last   = (need0 && need1) ? 2'd3 : 2'd1;
  wire        use1   = need1 && !bidx[1];
  wire [15:0] smp    = use1 ? s1 : s0;
  wire        ready  = (got0 || !need0) && (got1 || !need1);

  assign adc_wait  = (st == S_WAIT);
  assign adc0_diff = (st == S_WAIT || st == S_WR) && sel[2];
  assign mem_we    = (st == S_WR);
  assign mem_addr  = addr;
  assign mem_wdata = bidx[0] ? smp[7:0] : smp[15:8];
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign ins_ptr   = ptr;

  always_ff @(posedge clk) begin
    if (reg_we && !reg_addr[PW]) ibuf[reg_addr[PW-1:0]] <= reg_wdata[7:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; bnd <= '0; lim <= '0; base <= '0;
      rcnt <= '0; addr <= '0; sel <= '0; got0 <= 1'b0; got1 <= 1'b0;
      s0 <= '0; s1 <= '0; bidx <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we) begin
        case (reg_addr[2:0])
          3'd0: bnd        <= reg_wdata[PW-1:0];
          3'd1: lim[7:0]   <= reg_wdata;
          3'd2: lim[15:8]  <= reg_wdata;
          3'd3: base[7:0]  <= reg_wdata;
          3'd4: base[15:8] <= reg_wdata;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (start) begin
          ptr <= bnd; rcnt <= lim; addr <= base; st <= S_FETCH;
        end
        S_FETCH: begin
          sel <= fi[2:0]; got0 <= 1'b0; got1 <= 1'b0; bidx <= '0;
          if (fi_eop) begin
            ptr <= bnd;
            if (!fi[3]) begin st <= S_IDLE; done_q <= 1'b1; end
          end else st <= S_WAIT;
        end
        S_WAIT: begin
          if (adc0_rdy && need0) begin s0 <= adc0_data; got0 <= 1'b1; end
          if (adc1_rdy && need1) begin s1 <= adc1_data; got1 <= 1'b1; end
          if (ready) st <= S_WR;
        end
        S_WR: begin
          bidx <= bidx + 2'd1;
          addr <= addr + 1'b1;
          if (bidx == last) begin
            st <= S_FETCH;
            if (rcnt == CW'(1)) begin
              rcnt <= lim; ptr <= ptr + 1'b1;
            end else rcnt <= rcnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_dma_seq_chk.sv
module adc_dma_seq_chk #(
  parameter int PW  = 6,
  parameter int MAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           mem_we,
  input logic           adc_wait,
  input logic [MAW-1:0] mem_addr,
  input logic [PW-1:0]  ins_ptr,
  input logic [PW-1:0]  bnd
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R1
  AST_WAIT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    adc_wait |-> busy && !mem_we); // R3
  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == MAW'($past(mem_addr) + 1'b1)); // R9
  AST_PTR_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && ins_ptr != $past(ins_ptr)
      |-> ins_ptr == PW'($past(ins_ptr) + 1'b1) || ins_ptr == bnd); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy) && ins_ptr == bnd); // R8
endmodule

bind adc_dma_seq adc_dma_seq_chk #(.PW(PW), .MAW(MAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_we(mem_we), .adc_wait(adc_wait), .mem_addr(mem_addr),
  .ins_ptr(ins_ptr), .bnd(bnd)
);

// File: tb/adc_dma_seq_bench.sv
module adc_dma_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, start = 1'b0, adc0_rdy = 1'b0, adc1_rdy = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [15:0] adc0_data = '0, adc1_data = '0;
  logic adc_wait, adc0_diff, mem_we, busy, done;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [5:0] ins_ptr;

  int n_cmp = 0, n_bad = 0, n_wr = 0;
  logic [15:0] exp_addr;
  logic [23:0] exp_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  adc_dma_seq u_adc_dma_seq (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && mem_we) begin
    n_wr++;
    if (exp_q.size() == 0) chk(0, "R3 unexpected write", {8'h0, mem_addr, mem_wdata}, 0);
    else begin
      logic [23:0] e;
      e = exp_q.pop_front();
      chk({mem_addr, mem_wdata} == e, "R4/R9 byte", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
    end
  end

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic push_smp(input logic [15:0] d);
    exp_q.push_back({exp_addr, d[15:8]}); exp_addr++;
    exp_q.push_back({exp_addr, d[7:0]});  exp_addr++;
  endtask

  task automatic pulse(input bit which, input logic [15:0] d);
    @(negedge clk);
    if (which) begin adc1_rdy = 1'b1; adc1_data = d; end
    else begin adc0_rdy = 1'b1; adc0_data = d; end
    @(negedge clk);
    adc0_rdy = 1'b0; adc1_rdy = 1'b0; adc0_data = 16'hDEAD; adc1_data = 16'hBEEF;
  endtask

  task automatic wait_w();
    while (!adc_wait) @(negedge clk);
  endtask

  task automatic run_pass(input logic [7:0] ins, input logic [15:0] d0, input logic [15:0] d1, input bit a0_first);
    bit n0, n1;
    n0 = ins[4] | ins[6]; n1 = ins[5];
    wait_w();
    chk(adc0_diff == ins[6], "R5 diff flag", adc0_diff, ins[6]);
    if (n1) push_smp(d1);
    if (n0) push_smp(d0);
    if (!n0) pulse(0, 16'h5555);
    if (!n1) pulse(1, 16'h6666);
    if (n0 && n1) begin
      if (a0_first) begin pulse(0, d0); pulse(1, d1); end
      else begin pulse(1, d1); pulse(0, d0); end
    end else if (n0) pulse(0, d0);
    else pulse(1, d1);
    while (adc_wait) @(negedge clk);
  endtask

  task automatic wait_done(input logic [5:0] b);
    while (!done) @(negedge clk);
    chk(!busy, "R8 busy low at done", busy, 0);
    chk(ins_ptr == b, "R8 pointer at boundary", ins_ptr, b);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] prog [4];
    prog[0] = 8'h10; prog[1] = 8'h20; prog[2] = 8'h30; prog[3] = 8'h40;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we, "R1 reset state", {busy, done, mem_we}, 0);
    rst_n = 1'b1;

    // R11 register map programming
    for (int i = 0; i < 4; i++) wr_reg(7'h10 + 7'(i), prog[i]);
    wr_reg(7'h14, 8'h00);
    wr_reg(7'h40, 8'h10);
    wr_reg(7'h41, 8'h02); wr_reg(7'h42, 8'h00);
    wr_reg(7'h43, 8'h00); wr_reg(7'h44, 8'h10);

    pulse(0, 16'h1111); pulse(1, 16'h2222);
    repeat (3) @(negedge clk);
    chk(n_wr == 0 && !busy, "R3 idle pulses ignored", n_wr, 0);

    exp_addr = 16'h1000;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(ins_ptr == 6'h10 && busy, "R2 pointer from boundary", ins_ptr, 6'h10);

    for (int i = 0; i < 4; i++) begin
      for (int p = 0; p < 2; p++) begin
        wait_w();
        chk(ins_ptr == 6'h10 + 6'(i), "R6 pointer per pass", ins_ptr, 6'h10 + 6'(i));
        if (i == 2 && p == 0) begin
          pulse_start();
          chk(ins_ptr == 6'h12 && busy, "R12 start ignored while busy", ins_ptr, 6'h12);
        end
        run_pass(prog[i], 16'hA000 + 16'(i * 2 + p), 16'hC000 + 16'(i * 2 + p), p == 1);
      end
    end
    wait_done(6'h10);
    chk(n_wr == 20, "R6 total bytes", n_wr, 20);

    // second program: pointer wrap, continuous restart, address wrap
    wr_reg(7'h3F, 8'h20); wr_reg(7'h00, 8'h10); wr_reg(7'h01, 8'h80);
    wr_reg(7'h40, 8'h3F);
    wr_reg(7'h41, 8'h01);
    wr_reg(7'h43, 8'hFE); wr_reg(7'h44, 8'hFF);
    exp_addr = 16'hFFFE;
    pulse_start();
    wait_w();
    chk(ins_ptr == 6'h3F, "R2 boundary 0x3F", ins_ptr, 6'h3F);
    run_pass(8'h20, 16'h0, 16'h1234, 0);
    wait_w();
    chk(ins_ptr == 6'h00, "R10 pointer wrap", ins_ptr, 0);
    run_pass(8'h10, 16'h5678, 16'h0, 0);
    wait_w();
    chk(ins_ptr == 6'h3F && busy, "R7 continuous restart", ins_ptr, 6'h3F);
    wr_reg(7'h01, 8'h00);
    run_pass(8'h20, 16'h0, 16'h9ABC, 0);
    run_pass(8'h10, 16'hDEF0, 16'h0, 0);
    wait_done(6'h3F);
    chk(n_wr == 28, "R9 bytes across wrap", n_wr, 28);
    chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule